// File: doc/BRIEF.md
# Cyclic Prefix Inserter

This block sits after an inverse FFT in an OFDM transmitter. It takes each time-domain symbol as a stream of samples and sends it out again with a guard interval in front. The guard interval is a copy of the last CP samples of the symbol. Each symbol therefore leaves the block as N + CP samples: the tail copy first, then the complete symbol from its first sample.

Two symbol sizes are supported. The short mode uses 64-sample symbols with a 16-sample prefix, or a 32-sample prefix when the symbol is marked as a preamble. The long mode uses 256-sample symbols with a prefix of 8, 16, 32 or 64 samples, chosen by a two-bit selector. The configuration inputs are sampled once per symbol, together with its first input sample.

The storage has two banks. While one stored symbol is read out, the next one can be written into the other bank. Both sides use a valid/ready handshake.

The write sequencer has two states. WR_HEAD waits for the first sample of a symbol. On that sample it latches the configuration and moves to WR_FILL. WR_FILL accepts the rest of the symbol and returns to WR_HEAD on the last sample. At that point it marks the bank full and switches to the other bank.

The read sequencer has three states. RD_IDLE waits until the current read bank is full. It then loads that bank's lengths and moves to RD_PREFIX, starting at address N - CP. RD_PREFIX sends CP samples and moves to RD_BODY, starting at address 0. RD_BODY sends N samples and returns to RD_IDLE on the last one. At that point it releases the bank and switches to the other bank.

Top module: `cp_inserter`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: For a symbol of N samples with prefix length CP, the output is N + CP samples: input samples N-CP to N-1 in order, then input samples 0 to N-1 in order.
- R3: With cfg_large = 0 and cfg_preamble = 0, N is 64 and CP is 16, whatever the value of cfg_cp_sel.
- R4: With cfg_large = 0 and cfg_preamble = 1, N is 64 and CP is 32.
- R5: With cfg_large = 1, N is 256 and CP is 8, 16, 32 or 64 for cfg_cp_sel = 0, 1, 2 or 3. cfg_preamble has no effect in this mode.
- R6: The configuration inputs are sampled only at the first accepted sample of a symbol. Changing them during the rest of that symbol does not change its length or its prefix.
- R7: Once the first prefix sample of a symbol is presented, out_valid stays 1 until the last body sample of that symbol is accepted. There is no gap between prefix and body.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values into the next cycle.
- R9: A second symbol can be written while the first one is stored and unread. in_ready goes to 0 only when both banks hold unread symbols, and a full bank is never written.
- R10: Symbols leave the block in the order they arrived. No sample is output without a matching input symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_data | input | DW | Input time-domain sample |
| cfg_large | input | 1 | 1 selects the 256-sample mode, 0 selects the 64-sample mode |
| cfg_cp_sel | input | 2 | Prefix length select in the 256-sample mode |
| cfg_preamble | input | 1 | Selects the longer prefix in the 64-sample mode |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | DW | Output sample (prefix, then body) |

## Verification
The bench drives every prefix setting in both modes, plus a long-mode symbol with the preamble flag set. A design that decoded the selector or the preamble flag wrongly would shift the prefix start and emit the wrong tail samples.

On every sample after the first of a symbol, the bench drives the inverse of the true configuration. A design that read the configuration all the time instead of latching it would cut symbols short or run them long.

The bench fills both banks while holding the output stalled. A design that reported in_ready wrongly, or overwrote a bank that had not been read, would fail there. Random-looking stalls test that data and valid are held under backpressure and that valid never drops between the prefix and the body.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

    typedef enum logic [0:0] {
        WR_HEAD = 1'b0,
        WR_FILL = 1'b1
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_PREFIX = 2'd1,
        RD_BODY   = 2'd2
    } rd_state_e;

    // Prefix length in long mode: the base length doubled once per select step.
    function automatic int unsigned long_cp_len(input logic [1:0] sel, input int unsigned base);
        return base << sel;
    endfunction

endpackage

// File: rtl/cpi_wr_seq.sv
module cpi_wr_seq
    import cpi_pkg::*;
#(
    parameter int SHORT_N      = 64,
    parameter int LONG_N       = 256,
    parameter int SHORT_CP     = 16,
    parameter int SHORT_PRE_CP = 32,
    parameter int LONG_CP_BASE = 8,
    localparam int LW = $clog2(LONG_N) + 1,
    localparam int AW = $clog2(LONG_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 cfg_large,
    input  logic [1:0]           cfg_cp_sel,
    input  logic                 cfg_preamble,
    input  logic [1:0]           bank_full,
    output logic                 in_ready,
    output logic                 wr_en,
    output logic                 wr_bank,
    output logic [AW-1:0]        wr_addr,
    output logic                 set_full,
    output logic [1:0][LW-1:0]   bank_n,
    output logic [1:0][LW-1:0]   bank_cp
);

    wr_state_e       state_q, state_d;
    logic [LW-1:0]   wcnt_q, wcnt_d;
    logic [LW-1:0]   cur_n_q;
    logic            bank_q;
    logic [LW-1:0]   new_n, new_cp;
    logic            last_beat;

    // Lengths decoded from the configuration pins
    always_comb begin
        new_n = cfg_large ? LW'(LONG_N) : LW'(SHORT_N);
        if (cfg_large)
            new_cp = LW'(long_cp_len(cfg_cp_sel, LONG_CP_BASE));
        else
            new_cp = cfg_preamble ? LW'(SHORT_PRE_CP) : LW'(SHORT_CP);
    end

    assign in_ready  = !bank_full[bank_q];
    assign wr_en     = in_valid && in_ready;
    assign wr_bank   = bank_q;
    assign wr_addr   = wcnt_q[AW-1:0];
    assign last_beat = wr_en && (state_q == WR_FILL) && (wcnt_q == cur_n_q - LW'(1));
    assign set_full  = last_beat;

    // Next state
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            WR_HEAD: if (wr_en) begin
                state_d = WR_FILL;
                wcnt_d  = LW'(1);
            end
            WR_FILL: if (wr_en) begin
                if (last_beat) begin
                    state_d = WR_HEAD;
                    wcnt_d  = '0;
                end else begin
                    wcnt_d  = wcnt_q + LW'(1);
                end
            end
            default: state_d = WR_HEAD;
        endcase
    end

    // State register and per-bank configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_HEAD;
            wcnt_q  <= '0;
            cur_n_q <= LW'(SHORT_N);
            bank_q  <= 1'b0;
            bank_n  <= '0;
            bank_cp <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            if (state_q == WR_HEAD && wr_en) begin
                cur_n_q         <= new_n;
                bank_n[bank_q]  <= new_n;
                bank_cp[bank_q] <= new_cp;
            end
            if (last_beat)
                bank_q <= ~bank_q;
        end
    end

    // R6: the length in use does not move while a symbol is being filled
    assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_FILL && state_d == WR_FILL) |=> $stable(cur_n_q))
        else $error("symbol length changed mid-symbol");

endmodule

// File: rtl/cpi_bank_mem.sv
module cpi_bank_mem #(
    parameter int DW = 16,
    parameter int AW = 8,
    localparam int DEPTH = 2 ** AW,
    localparam int NBANK = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          set_full,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    input  logic          clr_full,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    full
);

    logic [DW-1:0] mem [0:NBANK*DEPTH-1];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_bank, wr_addr}] <= wr_data;
    end

    assign rd_data = mem[{rd_bank, rd_addr}];

    for (genvar b = 0; b < NBANK; b++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                full[b] <= 1'b0;
            else if (set_full && wr_bank == 1'(b))
                full[b] <= 1'b1;
            else if (clr_full && rd_bank == 1'(b))
                full[b] <= 1'b0;
        end
    end

    // R9: the writer never targets a bank still holding an unread symbol
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full[wr_bank])
        else $error("write into full bank");

    // R10: the reader releases only a bank that it holds
    assert_release_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_full |-> full[rd_bank])
        else $error("release of empty bank");

endmodule

// File: rtl/cpi_rd_fsm.sv
module cpi_rd_fsm
    import cpi_pkg::*;
#(
    parameter int LONG_N = 256,
    localparam int LW = $clog2(LONG_N) + 1,
    localparam int AW = $clog2(LONG_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         full,
    input  logic [1:0][LW-1:0] bank_n,
    input  logic [1:0][LW-1:0] bank_cp,
    input  logic               out_ready,
    output logic               out_valid,
    output logic               rd_bank,
    output logic [AW-1:0]      rd_addr,
    output logic               clr_full
);

    rd_state_e     state_q, state_d;
    logic [LW-1:0] raddr_q, raddr_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] n_q, cp_q;
    logic          bank_q;
    logic          fire;
    logic          body_end;

    assign fire     = (state_q != RD_IDLE) && out_ready;
    assign body_end = (state_q == RD_BODY) && fire && (raddr_q == n_q - LW'(1));

    // Next state and address sequencing
    always_comb begin
        state_d = state_q;
        raddr_d = raddr_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RD_IDLE: if (full[bank_q]) begin
                state_d = RD_PREFIX;
                raddr_d = bank_n[bank_q] - bank_cp[bank_q];
                cnt_d   = '0;
            end
            RD_PREFIX: if (fire) begin
                if (cnt_q == cp_q - LW'(1)) begin
                    state_d = RD_BODY;
                    raddr_d = '0;
                end else begin
                    raddr_d = raddr_q + LW'(1);
                    cnt_d   = cnt_q + LW'(1);
                end
            end
            RD_BODY: if (fire) begin
                if (body_end)
                    state_d = RD_IDLE;
                else
                    raddr_d = raddr_q + LW'(1);
            end
            default: state_d = RD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            raddr_q <= '0;
            cnt_q   <= '0;
            n_q     <= '0;
            cp_q    <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            raddr_q <= raddr_d;
            cnt_q   <= cnt_d;
            if (state_q == RD_IDLE && full[bank_q]) begin
                n_q  <= bank_n[bank_q];
                cp_q <= bank_cp[bank_q];
            end
            if (body_end)
                bank_q <= ~bank_q;
        end
    end

    // Outputs
    always_comb begin
        out_valid = (state_q != RD_IDLE);
        rd_bank   = bank_q;
        rd_addr   = raddr_q[AW-1:0];
        clr_full  = body_end;
    end

    // R7: the prefix always runs straight into the body
    assert_prefix_to_body_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_PREFIX) |=> (state_q != RD_IDLE))
        else $error("gap after prefix");

    // R8: a stalled output keeps its read position
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(raddr_q) && $stable(bank_q)))
        else $error("read position moved under stall");

    // R5: every prefix length in use is a power of two
    assert_cp_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RD_IDLE) |-> ($countones(cp_q) == 1))
        else $error("illegal prefix length");

endmodule

// File: rtl/cp_inserter.sv
module cp_inserter #(
    parameter int DW           = 16,
    parameter int SHORT_N      = 64,
    parameter int LONG_N       = 256,
    parameter int SHORT_CP     = 16,
    parameter int SHORT_PRE_CP = 32,
    parameter int LONG_CP_BASE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          cfg_large,
    input  logic [1:0]    cfg_cp_sel,
    input  logic          cfg_preamble,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);

    localparam int LW = $clog2(LONG_N) + 1;
    localparam int AW = $clog2(LONG_N);

    logic               wr_en, wr_bank, set_full;
    logic [AW-1:0]      wr_addr;
    logic [1:0][LW-1:0] bank_n, bank_cp;
    logic [1:0]         full;
    logic               rd_bank, clr_full;
    logic [AW-1:0]      rd_addr;

    cpi_wr_seq #(
        .SHORT_N(SHORT_N), .LONG_N(LONG_N), .SHORT_CP(SHORT_CP),
        .SHORT_PRE_CP(SHORT_PRE_CP), .LONG_CP_BASE(LONG_CP_BASE)
    ) wr_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cfg_large(cfg_large), .cfg_cp_sel(cfg_cp_sel), .cfg_preamble(cfg_preamble),
        .bank_full(full), .in_ready(in_ready), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .set_full(set_full), .bank_n(bank_n), .bank_cp(bank_cp)
    );

    cpi_bank_mem #(.DW(DW), .AW(AW)) mem_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(in_data), .set_full(set_full),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .clr_full(clr_full),
        .rd_data(out_data), .full(full)
    );

    cpi_rd_fsm #(.LONG_N(LONG_N)) rd_i (
        .clk(clk), .rst_n(rst_n), .full(full), .bank_n(bank_n), .bank_cp(bank_cp),
        .out_ready(out_ready), .out_valid(out_valid), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .clr_full(clr_full)
    );

    // R8: held output sample does not change at the ports
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data))
        else $error("out_data changed under stall");

    // R1: nothing is presented in the cycle right after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid)
        else $error("out_valid after reset");

endmodule

// File: tb/cp_inserter_tb_top.sv
`timescale 1ns/1ps
module cp_inserter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        cfg_large = 1'b0;
    logic [1:0]  cfg_cp_sel = 2'd0;
    logic        cfg_preamble = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    bit hold = 0;
    bit stall = 0;
    int sent = 0;
    int done_syms = 0;

    int q_n[$];
    int q_cp[$];
    int q_id[$];

    always #2 clk = ~clk;

    cp_inserter #(.DW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_large(cfg_large), .cfg_cp_sel(cfg_cp_sel),
        .cfg_preamble(cfg_preamble), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sends one symbol; true configuration on the first sample, inverted afterwards (R6)
    task automatic send_sym(input int id, input bit lg, input int sel, input bit pre, input string req);
        int n, cp;
        n  = lg ? 256 : 64;
        cp = lg ? (8 << sel) : (pre ? 32 : 16);
        q_n.push_back(n); q_cp.push_back(cp); q_id.push_back(id);
        sent++;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = {id[7:0], i[7:0]};
            if (i == 0) begin
                cfg_large = lg; cfg_cp_sel = sel[1:0]; cfg_preamble = pre;
            end else begin
                cfg_large = ~lg; cfg_cp_sel = ~sel[1:0]; cfg_preamble = ~pre;
            end
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        $display("sent symbol %0d for %s (N=%0d CP=%0d)", id, req, n, cp);
    endtask

    // Output monitor: drives out_ready, checks R2/R7/R8/R10 against the queues
    initial begin
        int pos = 0;
        int cyc = 0;
        bit prev_stall = 0;
        logic [15:0] prev_data = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pos = 0; prev_stall = 0;
            end else begin
                bit rdy;
                if (prev_stall)
                    chk(out_valid && out_data == prev_data, "R8 hold", int'(out_data), int'(prev_data));
                if (pos != 0)
                    chk(out_valid, "R7 no gap", int'(out_valid), 1);
                rdy = hold ? 1'b0 : (stall ? (cyc % 3 != 0) : 1'b1);
                out_ready = rdy;
                if (out_valid && rdy) begin
                    if (q_n.size() == 0) begin
                        chk(0, "R10 spurious output", int'(out_data), -1);
                    end else begin
                        int n, cp, idx;
                        logic [15:0] exp;
                        n = q_n[0]; cp = q_cp[0];
                        idx = (pos < cp) ? (n - cp + pos) : (pos - cp);
                        exp = {q_id[0][7:0], idx[7:0]};
                        chk(out_data == exp, "R2/R10 sample", int'(out_data), int'(exp));
                        pos++;
                        if (pos == n + cp) begin
                            pos = 0;
                            void'(q_n.pop_front()); void'(q_cp.pop_front()); void'(q_id.pop_front());
                            done_syms++;
                        end
                    end
                end
                prev_stall = out_valid && !rdy;
                prev_data  = out_data;
                cyc++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d symbols", done_syms, sent);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R9: fill both banks with the output stalled
        hold = 1;
        send_sym(0, 1'b0, 0, 1'b0, "R3");
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 second bank free", int'(in_ready), 1);
        chk(out_valid == 1'b1, "R9 first symbol presented", int'(out_valid), 1);
        send_sym(1, 1'b0, 2, 1'b1, "R4");
        chk(in_ready == 1'b0, "R9 both banks full", int'(in_ready), 0);
        hold = 0;

        // R5 sweep, R3 with nonzero select, R5 preamble ignored
        send_sym(2, 1'b1, 0, 1'b0, "R5 cp8");
        send_sym(3, 1'b1, 1, 1'b0, "R5 cp16");
        send_sym(4, 1'b1, 2, 1'b0, "R5 cp32");
        send_sym(5, 1'b1, 3, 1'b0, "R5 cp64");
        send_sym(6, 1'b1, 1, 1'b1, "R5 preamble ignored");
        send_sym(7, 1'b0, 3, 1'b0, "R3 select ignored");
        // Backpressure phase (R8, R7)
        stall = 1;
        send_sym(8, 1'b0, 0, 1'b1, "R4 stalled");
        send_sym(9, 1'b1, 3, 1'b0, "R5 stalled");
        send_sym(10, 1'b0, 0, 1'b0, "R3 stalled");
        send_sym(11, 1'b1, 0, 1'b1, "R6 stalled");
        stall = 0;
        send_sym(12, 1'b1, 2, 1'b1, "R6");

        while (done_syms < sent) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(done_syms == 13, "R10 symbol count", done_syms, 13);
        chk(out_valid == 1'b0, "R10 idle at end", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 banks released", int'(in_ready), 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule